// File: doc/BRIEF.md
# CAN Error Warning Interrupt Flags

This block watches the transmit and receive error counters of a CAN controller and reports when either one enters the warning region, a count of 96 or more. For each direction it keeps a level bit that follows the counter against that threshold. It also keeps a sticky interrupt flag. The flag is set only when the level bit goes from 0 to 1, and only while warning reporting is enabled. Software clears a flag by writing a 1 to its bit through a simple write port.

Each flag has a mask input. The block drives one interrupt line from a register. That line is high while any flag is set together with its mask bit. The four live bits are read from a status word. Its other bits read 0, and writes to them have no effect. The counters themselves, bus-off handling and the protocol engine are outside this block.

Top module: `can_warn_regs`

## Requirements
- R1: While `rst_ni` is low, and after reset, `stat_o` and `irq_o` are all zero.
- R2: Bit 0 of `stat_o` (transmit warning level) is 1 exactly when `tx_cnt_i` was at least 96 at the previous rising clock edge.
- R3: Bit 1 of `stat_o` (receive warning level) is 1 exactly when `rx_cnt_i` was at least 96 at the previous rising clock edge.
- R4: Bit 2 of `stat_o` (transmit warning flag) becomes 1 on the edge where the transmit level goes from 0 to 1, provided `warn_en_i` is 1 at that edge. It stays 1 until it is cleared.
- R5: Bit 3 of `stat_o` (receive warning flag) behaves like R4, but for the receive level.
- R6: A flag is not set by a level rise that happens while `warn_en_i` is 0. Enabling later, while the level stays high, does not set the flag. A level that stays high after a clear does not set the flag again.
- R7: With `wr_en_i` high, a 1 in `wr_data_i` bit 2 clears the transmit flag and a 1 in bit 3 clears the receive flag. A 0 in those bits leaves the flag unchanged. All other write data bits are ignored.
- R8: If a flag's set event and its write-one clear arrive on the same edge, the flag ends up 1.
- R9: `irq_o` is registered. After each edge it equals (transmit flag AND `tx_msk_i`) OR (receive flag AND `rx_msk_i`), using the new flag values and the mask values sampled at that edge.
- R10: Bits 7 to 4 of `stat_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_cnt_i | input | CNT_W | Transmit error counter value |
| rx_cnt_i | input | CNT_W | Receive error counter value |
| warn_en_i | input | 1 | Allows the warning flags to be set |
| tx_msk_i | input | 1 | Interrupt mask for the transmit warning flag |
| rx_msk_i | input | 1 | Interrupt mask for the receive warning flag |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_data_i | input | STAT_W | Write data; a 1 in a flag bit clears that flag |
| stat_o | output | STAT_W | Status word: levels, flags, zero padding |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The case that is hardest to reach is a threshold crossing that lands on the very edge where software writes a 1 to the same flag. The same goes for a crossing that happens while reporting is disabled, with reporting then turned on while the counter stays high.

The sweep holds both counters in a narrow band around 96 (90 to 102 for transmit, 94 to 98 for receive). It then cycles the enable, the masks and the write data on unrelated periods. This makes rising edges, held levels, enable changes and clears occur together on the same edge many times. Directed steps force the same-edge set-and-clear collision and the late-enable case, and check them on their own.

// File: rtl/can_warn_pkg.sv
package can_warn_pkg;
  localparam int NCH       = 2;
  localparam int LVL_BASE  = 0;
  localparam int FLAG_BASE = 2;

  typedef enum logic [0:0] {
    CH_TX = 1'b0,
    CH_RX = 1'b1
  } warn_ch_e;
endpackage

// File: rtl/warn_detect.sv
module warn_detect #(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             lvl_o,
  output logic             rise_o
);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(WARN_LIM);

  logic above;
  logic lvl_q;

  assign above = (cnt_i >= LIM_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= above;
  end

  // rising transition: above now, registered level still low
  assign rise_o = above & ~lvl_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/w1c_flag.sv
module w1c_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic flag_d_o
);
  logic flag_q;

  // set has priority over a same-cycle clear
  assign flag_d_o = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d_o;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/warn_irq.sv
module warn_irq #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_d_i,
  input  logic [N-1:0] msk_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_d_i & msk_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/can_warn_regs.sv
module can_warn_regs
  import can_warn_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int STAT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic              warn_en_i,
  input  logic              tx_msk_i,
  input  logic              rx_msk_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  localparam int USED_W = FLAG_BASE + NCH;

  logic [CNT_W-1:0] cnt [NCH];
  logic [NCH-1:0]   msk;
  logic [NCH-1:0]   lvl;
  logic [NCH-1:0]   rise;
  logic [NCH-1:0]   flag;
  logic [NCH-1:0]   flag_d;
  logic             unused_wr;

  assign cnt[CH_TX] = tx_cnt_i;
  assign cnt[CH_RX] = rx_cnt_i;
  assign msk[CH_TX] = tx_msk_i;
  assign msk[CH_RX] = rx_msk_i;
  assign unused_wr  = ^wr_data_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    warn_detect #(
      .CNT_W    (CNT_W),
      .WARN_LIM (WARN_LIM)
    ) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt[ch]),
      .lvl_o  (lvl[ch]),
      .rise_o (rise[ch])
    );

    w1c_flag u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (rise[ch] & warn_en_i),
      .clr_i    (wr_en_i & wr_data_i[FLAG_BASE+ch]),
      .flag_o   (flag[ch]),
      .flag_d_o (flag_d[ch])
    );
  end

  warn_irq #(.N(NCH)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flag_d_i (flag_d),
    .msk_i    (msk),
    .irq_o    (irq_o)
  );

  always_comb begin
    stat_o = '0;
    stat_o[LVL_BASE  +: NCH] = lvl;
    stat_o[FLAG_BASE +: NCH] = flag;
  end

  if (USED_W > STAT_W) begin : g_bad_cfg
    initial $error("status word too narrow");
  end
endmodule

// File: rtl/can_warn_regs_chk.sv
module can_warn_regs_chk #(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int STAT_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  tx_cnt_i,
  input logic [CNT_W-1:0]  rx_cnt_i,
  input logic              warn_en_i,
  input logic              tx_msk_i,
  input logic              rx_msk_i,
  input logic              wr_en_i,
  input logic [STAT_W-1:0] wr_data_i,
  input logic [STAT_W-1:0] stat_o,
  input logic              irq_o
);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(WARN_LIM);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |=> (stat_o == '0 && !irq_o)); // R1

  AST_TX_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (stat_o[0] == $past(tx_cnt_i >= LIM_C))); // R2

  AST_RX_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (stat_o[1] == $past(rx_cnt_i >= LIM_C))); // R3

  AST_TX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt_i >= LIM_C && !stat_o[0] && warn_en_i) |=> stat_o[2]); // R4

  AST_RX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt_i >= LIM_C && !stat_o[1] && warn_en_i) |=> stat_o[3]); // R5

  AST_NO_SET_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!warn_en_i && !stat_o[2]) |=> !stat_o[2]); // R6

  AST_TX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[2] && stat_o[0]) |=> !stat_o[2]); // R7

  AST_KEEP_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[3] && !(wr_en_i && wr_data_i[3])) |=> stat_o[3]); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (irq_o == ((stat_o[2] && $past(tx_msk_i)) ||
                           (stat_o[3] && $past(rx_msk_i))))); // R9

  AST_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[STAT_W-1:4] == '0); // R10
endmodule

bind can_warn_regs can_warn_regs_chk #(
  .CNT_W    (CNT_W),
  .WARN_LIM (WARN_LIM),
  .STAT_W   (STAT_W)
) i_chk (.*);

// File: tb/test_can_warn_regs.sv
`timescale 1ns/1ps
module test_can_warn_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_cnt = '0, rx_cnt = '0;
  logic       warn_en = 1'b0, tx_msk = 1'b0, rx_msk = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] stat;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit m_tl, m_rl, m_tf, m_rf, m_irq;

  always #10 clk = ~clk;

  can_warn_regs i_can_warn_regs (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tx_cnt_i  (tx_cnt),
    .rx_cnt_i  (rx_cnt),
    .warn_en_i (warn_en),
    .tx_msk_i  (tx_msk),
    .rx_msk_i  (rx_msk),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .stat_o    (stat),
    .irq_o     (irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk("R2 tx level", 8'(stat[0]), 8'(m_tl));
    chk("R3 rx level", 8'(stat[1]), 8'(m_rl));
    chk("R4 tx flag", 8'(stat[2]), 8'(m_tf));
    chk("R5 rx flag", 8'(stat[3]), 8'(m_rf));
    chk("R10 upper bits", 8'(stat[7:4]), 8'h00);
    chk("R9 irq", 8'(irq), 8'(m_irq));
  endtask

  // called at a negedge: drive, step model, wait one cycle, compare
  task automatic drive(int tx, int rx, bit en, bit tm, bit rm, bit we, logic [7:0] wd);
    bit n_tl, n_rl;
    tx_cnt = 8'(tx); rx_cnt = 8'(rx); warn_en = en;
    tx_msk = tm; rx_msk = rm; wr_en = we; wr_data = wd;
    n_tl = (tx >= 96);
    n_rl = (rx >= 96);
    m_tf = (n_tl && !m_tl && en) || (m_tf && !(we && wd[2]));
    m_rf = (n_rl && !m_rl && en) || (m_rf && !(we && wd[3]));
    m_tl = n_tl;
    m_rl = n_rl;
    m_irq = (m_tf && tm) || (m_rf && rm);
    @(negedge clk);
    chk_all();
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    tx_cnt = 8'd120; rx_cnt = 8'd120; warn_en = 1'b1; tx_msk = 1'b1; rx_msk = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 stat in reset", stat, 8'h00);
    chk("R1 irq in reset", 8'(irq), 8'h00);
    tx_cnt = '0; rx_cnt = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stat after reset", stat, 8'h00);
    chk("R1 irq after reset", 8'(irq), 8'h00);

    // R6: tx crosses while disabled, enable later while still high
    drive(95, 0, 0, 1, 1, 0, 8'h00);
    drive(96, 0, 0, 1, 1, 0, 8'h00);
    drive(100, 0, 1, 1, 1, 0, 8'h00);
    chk("R6 no flag after late enable", 8'(stat[2]), 8'h00);
    chk("R6 level high", 8'(stat[0]), 8'h01);

    // R4 rising edge with enable
    drive(10, 0, 1, 1, 1, 0, 8'h00);
    drive(96, 0, 1, 1, 0, 0, 8'h00);
    chk("R4 tx flag set at 96", 8'(stat[2]), 8'h01);
    chk("R9 irq from tx", 8'(irq), 8'h01);

    // R7: zero write and non-flag bits do nothing, one clears
    drive(97, 0, 1, 1, 0, 1, 8'h00);
    chk("R7 write 0 keeps flag", 8'(stat[2]), 8'h01);
    drive(97, 0, 1, 1, 0, 1, 8'hFB);
    chk("R7 other bits ignored", stat, 8'h05);
    drive(97, 0, 1, 1, 0, 1, 8'h04);
    chk("R7 write 1 clears", 8'(stat[2]), 8'h00);
    drive(99, 0, 1, 1, 0, 0, 8'h00);
    chk("R6 no reset after clear while high", 8'(stat[2]), 8'h00);

    // R8: rx set and clear on the same edge
    drive(99, 50, 1, 0, 1, 0, 8'h00);
    drive(99, 96, 1, 0, 1, 1, 8'h08);
    chk("R8 set wins rx", 8'(stat[3]), 8'h01);
    chk("R5 rx flag", 8'(stat[3]), 8'h01);
    drive(99, 96, 1, 0, 0, 0, 8'h00);
    chk("R9 irq masked off", 8'(irq), 8'h00);

    // near-exhaustive sweep around the threshold
    for (int i = 0; i < 4000; i++) begin
      drive(90 + (i * 5) % 13, 94 + (i * 3) % 5, (i % 11) != 0,
            i[4], i[5], (i % 3) == 0, 8'((i * 37) & 8'hFF));
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule